// File: doc/BRIEF.md
# Audio Serial Clock Divider Chain

This block derives the two timing references an audio serial port needs, a fast master clock and a slower bit clock, from a selectable source. Everything runs in the core clock domain. The internal source advances once per core cycle. The external source arrives as a sampled level and advances once on each of its rising edges. Each derived clock is produced in two forms: a 50% duty level, and a one-cycle enable pulse in the cycle that level rises. Each level also has a polarity-adjusted copy.

In the divided path the source passes through a prescaler (divide by 1 or 8), then a modulus counter (divide by 1 to 256), then a fixed toggle stage (divide by 2). The resulting master clock feeds a fine counter (divide by 1 to 16) that makes the bit clock. Two alternatives replace the divided path. A bypass mode passes the external source level through as the master clock. A pin-input mode takes the master clock from an outside pin. In both, only the fine counter divides. Software computes and programs all divider values. Each counter loads a new value only when it reloads.

Top module: `aud_clk_chain`

## Requirements
- R1: A synchronous reset, held for one or more cycles, drives all six outputs low and clears every counter.
- R2: In the divided path the master clock period is 2 x P x M source ticks. P is 1 when `pre_div_i`=0 and 8 when `pre_div_i`=1. M is `mod_i`+1, so the field holds M-1 and the range is 1 to 256. With the internal source, one tick is one core cycle.
- R3: In the divided path the master clock is high for exactly P x M source ticks and low for the same count.
- R4: `mclk_en_o` and `bclk_en_o` pulse for one cycle, once per period of their clock, in the cycle the matching level output goes high.
- R5: The bit clock period is F master clock periods, where F is `fine_i`+1 (range 1 to 16). It stays high for F master half-periods, and each bit clock edge falls in the same cycle as a master clock edge.
- R6: With `mck_drive_i`=1, `byp_i`=1 and `src_ext_i`=1, the master clock level copies `ext_clk_i` one cycle later, and `pre_div_i` and `mod_i` have no effect.
- R7: `byp_i` is ignored while `src_ext_i`=0. The divided path from the internal source stays in use.
- R8: With `mck_drive_i`=0, the master clock level copies `mck_pin_i` one cycle later. `src_ext_i`, `byp_i`, `pre_div_i` and `mod_i` are ignored. The bit clock is still divided by F.
- R9: `mclk_pol_o` equals `mclk_o` XOR `mck_inv_i`, and `bclk_pol_o` equals `bclk_o` XOR `bck_inv_i`. Both invert bits are sampled at the same edge as the level.
- R10: A new `mod_i` value written mid-count does not shorten or lengthen the half-period in progress. It first applies at the next reload.
- R11: With `src_ext_i`=1 and no bypass, the divided path counts rising edges of `ext_clk_i`, so the master period is 2 x P x M external periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| src_ext_i | input | 1 | Source select: 1 external, 0 core clock |
| ext_clk_i | input | 1 | Sampled level of the external source clock |
| mck_drive_i | input | 1 | 1 drives master clock internally, 0 takes it from pin |
| mck_pin_i | input | 1 | Master clock level arriving at the pin |
| byp_i | input | 1 | Bypass all master dividers (external source only) |
| pre_div_i | input | 1 | Prescaler: 0 divide by 1, 1 divide by 8 |
| mod_i | input | MOD_W | Modulus value minus one |
| fine_i | input | FINE_W | Bit clock fine divider value minus one |
| mck_inv_i | input | 1 | Invert master clock copy |
| bck_inv_i | input | 1 | Invert bit clock copy |
| mclk_en_o | output | 1 | Master clock rising-edge enable |
| mclk_o | output | 1 | Master clock level, 50% duty |
| mclk_pol_o | output | 1 | Polarity-adjusted master clock |
| bclk_en_o | output | 1 | Bit clock rising-edge enable |
| bclk_o | output | 1 | Bit clock level, 50% duty |
| bclk_pol_o | output | 1 | Polarity-adjusted bit clock |

## Verification
The bench builds the block with its default widths: an 8-bit modulus, a 4-bit fine field and a 3-bit prescaler count. This makes the full range of every field reachable, including M=256 with the divide-by-8 prescaler. The sweep covers every M from 1 to 16 against F from 1 to 3, every F from 1 to 16 at M=1, and the prescaler at several M. In each case the bench measures period and high time cycle by cycle against 2 x P x M x F. The external, bypass and pin paths are driven by generated levels of known period, which keeps their expected periods small enough to check by exact arithmetic.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

    typedef enum logic [1:0] {
        MSRC_DIV = 2'd0,
        MSRC_BYP = 2'd1,
        MSRC_PIN = 2'd2
    } msrc_e;

    typedef struct packed {
        logic ext_prev;
        logic mclk;
        logic mclk_en;
        logic mclk_pol;
        logic bclk;
        logic bclk_en;
        logic bclk_pol;
    } chain_st_t;

endpackage

// File: rtl/aud_cnt_div.sv
module aud_cnt_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    input  logic [W-1:0] load_i,
    output logic         tc_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    // Down-counter: fires when it is advanced at zero, then reloads from load_i.
    always_comb begin
        st_d = st_q;
        tc_o = adv_i && (st_q.cnt == '0);
        if (adv_i) begin
            if (tc_o) begin
                st_d.cnt = load_i;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RELOAD_TAKES_LOAD: assert property (@(posedge clk) disable iff (rst)
        tc_o |=> (st_q.cnt == $past(load_i))); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(st_q.cnt)); // R10

endmodule

// File: rtl/aud_clk_chain.sv
module aud_clk_chain
    import aud_clk_pkg::*;
#(
    parameter int MOD_W  = 8,
    parameter int FINE_W = 4,
    parameter int PRE_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_ext_i,
    input  logic              ext_clk_i,
    input  logic              mck_drive_i,
    input  logic              mck_pin_i,
    input  logic              byp_i,
    input  logic              pre_div_i,
    input  logic [MOD_W-1:0]  mod_i,
    input  logic [FINE_W-1:0] fine_i,
    input  logic              mck_inv_i,
    input  logic              bck_inv_i,
    output logic              mclk_en_o,
    output logic              mclk_o,
    output logic              mclk_pol_o,
    output logic              bclk_en_o,
    output logic              bclk_o,
    output logic              bclk_pol_o
);

    localparam logic [PRE_W-1:0] PRE_LOAD = PRE_W'((1 << PRE_W) - 1);

    chain_st_t st_d, st_q;
    msrc_e     msrc;
    logic      ext_rise;
    logic      src_tick;
    logic      pre_adv;
    logic      pre_tc;
    logic      mod_tc;
    logic      half_evt;
    logic      fine_tc;
    logic [PRE_W-1:0] pre_load;

    // Source and mode selection (combinational, feeds the counters)
    always_comb begin
        if (!mck_drive_i) begin
            msrc = MSRC_PIN;
        end else if (byp_i && src_ext_i) begin
            msrc = MSRC_BYP;
        end else begin
            msrc = MSRC_DIV;
        end
        ext_rise = ext_clk_i && !st_q.ext_prev;
        src_tick = src_ext_i ? ext_rise : 1'b1;
        pre_adv  = (msrc == MSRC_DIV) && src_tick;
        pre_load = pre_div_i ? PRE_LOAD : '0;
    end

    aud_cnt_div #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (pre_adv),
        .load_i (pre_load),
        .tc_o   (pre_tc)
    );

    aud_cnt_div #(.W(MOD_W)) u_mod (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (pre_tc),
        .load_i (mod_i),
        .tc_o   (mod_tc)
    );

    // Next master level and the half-period event that drives the fine stage
    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_clk_i;
        unique case (msrc)
            MSRC_PIN: st_d.mclk = mck_pin_i;
            MSRC_BYP: st_d.mclk = ext_clk_i;
            default:  st_d.mclk = st_q.mclk ^ mod_tc;
        endcase
        half_evt = st_d.mclk ^ st_q.mclk;
    end

    aud_cnt_div #(.W(FINE_W)) u_fine (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (half_evt),
        .load_i (fine_i),
        .tc_o   (fine_tc)
    );

    logic [6:0] unused_st;
    assign unused_st = {st_q.mclk_en, st_q.mclk_pol, st_q.bclk_en, st_q.bclk_pol, 3'b000};

    chain_st_t st_n;
    always_comb begin
        st_n          = st_d;
        st_n.bclk     = st_q.bclk ^ fine_tc;
        st_n.mclk_en  = st_d.mclk && !st_q.mclk;
        st_n.bclk_en  = st_n.bclk && !st_q.bclk;
        st_n.mclk_pol = st_d.mclk ^ mck_inv_i;
        st_n.bclk_pol = st_n.bclk ^ bck_inv_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_n;
        end
    end

    assign mclk_o     = st_q.mclk;
    assign mclk_en_o  = st_q.mclk_en;
    assign mclk_pol_o = st_q.mclk_pol;
    assign bclk_o     = st_q.bclk;
    assign bclk_en_o  = st_q.bclk_en;
    assign bclk_pol_o = st_q.bclk_pol;

    AST_MEN_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        mclk_en_o |-> (mclk_o && !$past(mclk_o))); // R4

    AST_BEN_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        bclk_en_o |-> (bclk_o && !$past(bclk_o))); // R4

    AST_BEDGE_WITH_MEDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(bclk_o) |-> !$stable(mclk_o)); // R5

    AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !mck_drive_i |=> (mclk_o == $past(mck_pin_i))); // R8

    AST_MPOL_COPY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mclk_pol_o == (mclk_o ^ $past(mck_inv_i)))); // R9

    AST_BPOL_COPY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bclk_pol_o == (bclk_o ^ $past(bck_inv_i)))); // R9

    AST_BYP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (mck_drive_i && byp_i && src_ext_i) |=> (mclk_o == $past(ext_clk_i))); // R6

endmodule

// File: tb/sim_aud_clk_chain.sv
module sim_aud_clk_chain;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_ext = 1'b0;
    logic       ext_clk = 1'b0;
    logic       mck_drive = 1'b1;
    logic       mck_pin = 1'b0;
    logic       byp = 1'b0;
    logic       pre_div = 1'b0;
    logic [7:0] mod_v = 8'd0;
    logic [3:0] fine_v = 4'd0;
    logic       mck_inv = 1'b0;
    logic       bck_inv = 1'b0;
    logic       mclk_en, mclk, mclk_pol, bclk_en, bclk, bclk_pol;

    logic ext_run = 1'b0;
    logic pin_run = 1'b0;
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    aud_clk_chain u0 (
        .clk         (clk),
        .rst         (rst),
        .src_ext_i   (src_ext),
        .ext_clk_i   (ext_clk),
        .mck_drive_i (mck_drive),
        .mck_pin_i   (mck_pin),
        .byp_i       (byp),
        .pre_div_i   (pre_div),
        .mod_i       (mod_v),
        .fine_i      (fine_v),
        .mck_inv_i   (mck_inv),
        .bck_inv_i   (bck_inv),
        .mclk_en_o   (mclk_en),
        .mclk_o      (mclk),
        .mclk_pol_o  (mclk_pol),
        .bclk_en_o   (bclk_en),
        .bclk_o      (bclk),
        .bclk_pol_o  (bclk_pol)
    );

    // External source: period of 4 core cycles
    initial forever begin
        repeat (2) @(negedge clk);
        if (ext_run) ext_clk = ~ext_clk;
    end

    // Pin master clock: period of 6 core cycles
    initial forever begin
        repeat (3) @(negedge clk);
        if (pin_run) mck_pin = ~mck_pin;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit sel_en(input bit use_b);
        return use_b ? bclk_en : mclk_en;
    endfunction

    function automatic bit sel_lv(input bit use_b);
        return use_b ? bclk : mclk;
    endfunction

    task automatic wait_en(input bit use_b);
        do @(negedge clk); while (!sel_en(use_b));
    endtask

    // Skip settling periods, then measure one full period and its high time.
    task automatic measure(input bit use_b, input int exp_per, input int exp_hi, input string req);
        int per;
        int hi;
        repeat (3) wait_en(use_b);
        per = 0;
        hi  = 1;
        forever begin
            @(negedge clk);
            per++;
            if (sel_en(use_b)) break;
            if (sel_lv(use_b)) hi++;
        end
        check(per == exp_per, {req, " period"}, per, exp_per);
        check(hi == exp_hi, {req, " high time"}, hi, exp_hi);
    endtask

    task automatic check_reset_low(input string req);
        check({mclk_en, mclk, mclk_pol, bclk_en, bclk, bclk_pol} == 6'b0, req,
              int'({mclk_en, mclk, mclk_pol, bclk_en, bclk, bclk_pol}), 0);
    endtask

    task automatic setup(input bit pre, input int m, input int f);
        rst     = 1'b1;
        pre_div = pre;
        mod_v   = 8'(m - 1);
        fine_v  = 4'(f - 1);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        mck_inv = 1'b1;
        bck_inv = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_low("R1 outputs low in reset");
        mck_inv = 1'b0;
        bck_inv = 1'b0;

        // R2 R3 R4 R5: sweep M 1..16 with F 1..3, prescaler bypassed
        for (int m = 1; m <= 16; m++) begin
            for (int f = 1; f <= 3; f++) begin
                setup(1'b0, m, f);
                measure(1'b0, 2 * m, m, "R2/R3/R4 master");
                measure(1'b1, 2 * m * f, m * f, "R5 bit");
            end
        end

        // R5: full fine range at M=1
        for (int f = 1; f <= 16; f++) begin
            setup(1'b0, 1, f);
            measure(1'b1, 2 * f, f, "R5 fine sweep");
        end

        // R2: prescaler divide by 8
        for (int m = 1; m <= 4; m++) begin
            setup(1'b1, m, 2);
            measure(1'b0, 16 * m, 8 * m, "R2 prescaled master");
            measure(1'b1, 32 * m, 16 * m, "R5 prescaled bit");
        end

        // R2: modulus upper limit
        setup(1'b0, 256, 1);
        measure(1'b0, 512, 256, "R2 M=256");
        setup(1'b1, 256, 1);
        measure(1'b0, 4096, 2048, "R2 P=8 M=256");

        // R1: reset mid-run clears outputs
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_low("R1 reset mid-run");
        rst = 1'b0;

        // R10: change modulus mid half-period
        setup(1'b0, 10, 1);
        repeat (2) wait_en(1'b0);
        mod_v = 8'd1;
        begin
            int hi;
            int lo;
            hi = 1;
            lo = 0;
            forever begin
                @(negedge clk);
                if (!mclk) break;
                hi++;
            end
            lo = 1;
            forever begin
                @(negedge clk);
                if (mclk) break;
                lo++;
            end
            check(hi == 10, "R10 old half-period kept", hi, 10);
            check(lo == 2, "R10 new value at reload", lo, 2);
        end

        // R7: bypass ignored with internal source
        byp = 1'b1;
        setup(1'b0, 2, 1);
        measure(1'b0, 4, 2, "R7 bypass ignored");
        byp = 1'b0;

        // R11: external source divided, ext period 4
        ext_run = 1'b1;
        src_ext = 1'b1;
        setup(1'b0, 3, 1);
        measure(1'b0, 24, 12, "R11 external divided");

        // R6: bypass external, P and M ignored
        byp = 1'b1;
        setup(1'b1, 7, 3);
        measure(1'b0, 4, 2, "R6 bypass master");
        measure(1'b1, 12, 6, "R6 bypass bit");

        // R9: polarity copies
        mck_inv = 1'b1;
        bck_inv = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(mclk_pol == (mclk ^ 1'b1), "R9 master inverted", mclk_pol, mclk ^ 1'b1);
            check(bclk_pol == bclk, "R9 bit plain", bclk_pol, bclk);
        end
        mck_inv = 1'b0;
        bck_inv = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(mclk_pol == mclk, "R9 master plain", mclk_pol, mclk);
            check(bclk_pol == (bclk ^ 1'b1), "R9 bit inverted", bclk_pol, bclk ^ 1'b1);
        end
        bck_inv = 1'b0;

        // R8: pin input, pin period 6, source and bypass ignored
        ext_run   = 1'b0;
        pin_run   = 1'b1;
        mck_drive = 1'b0;
        setup(1'b1, 5, 2);
        measure(1'b0, 6, 3, "R8 pin master");
        measure(1'b1, 12, 6, "R8 pin bit");
        byp     = 1'b0;
        src_ext = 1'b0;
        measure(1'b0, 6, 3, "R8 pin master, source internal");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule